// File: doc/BRIEF.md
# Multilayer Bus Matrix with Per-Slave Round-Robin Arbitration

This block connects three bus masters (one DMA layer and two processor layers) to three independent slave ports: code flash, SRAM and the peripheral bridge. Each master presents a single-beat request made of address, write enable and write data. It keeps that request asserted and unchanged until it sees ready. The top two address bits select the slave port. Masters that target different slave ports are connected in the same cycle and do not interfere with each other.

Each slave port has its own arbiter. When the slave port is idle, a lone requester is connected combinationally in the cycle it asks. When several masters ask together, a round-robin pointer chooses the winner, and the pointer then advances past the winner. A slave that holds ready low keeps its current owner, and no other master can take the port until that owner's beat has been accepted. An address in the fourth region reaches no slave. It is answered at once with ready and zero read data.

Top module: `mlx_matrix`

## Requirements
- R1: While reset is held and afterwards with no requests, every `s_sel_o` bit and every `m_ready_o` bit is 0.
- R2: The slave port is chosen by address bits [AW-1:AW-2]: 00 selects port 0 (flash), 01 selects port 1 (SRAM) and 10 selects port 2 (bridge). A selected port carries the granted master's address, write enable and write data. An unselected port drives zeros on all three.
- R3: A request with address bits [AW-1:AW-2] = 11 gets `m_ready_o` high in the same cycle with `m_rdata_o` = 0, and it selects no slave port.
- R4: A request to an idle slave port with no competitor asserts that port's `s_sel_o` in the same cycle. If the slave's ready is high, the beat completes in that cycle.
- R5: Masters that target three different slave ports are all served in the same cycle.
- R6: Out of reset every pointer is 0. With several requesters at an idle port, the first requester at or after the pointer wins, in cyclic order of master index. The pointer then becomes the winner's index plus one, modulo the master count.
- R7: While a granted beat waits on a low slave ready, the port stays with its owner: the grant, the address, the write enable and the write data do not change until the slave raises ready.
- R8: `m_ready_o` of a mapped request equals the target slave's ready while that master holds the port, and is 0 otherwise. `m_rdata_o` carries that slave's read data when `m_ready_o` is high, and is 0 when `m_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_req_i | input | NM | Request per master |
| m_addr_i | input | NM x AW | Address per master |
| m_we_i | input | NM | Write enable per master |
| m_wdata_i | input | NM x DW | Write data per master |
| m_ready_o | output | NM | Beat accepted, per master |
| m_rdata_o | output | NM x DW | Read data per master |
| s_sel_o | output | 3 | Port selected, per slave |
| s_addr_o | output | 3 x AW | Forwarded address per slave |
| s_we_o | output | 3 | Forwarded write enable per slave |
| s_wdata_o | output | 3 x DW | Forwarded write data per slave |
| s_ready_i | input | 3 | Slave ready per port |
| s_rdata_i | input | 3 x DW | Slave read data per port |

## Verification
Selection, forwarding, master ready and read data are combinational, so each is due in the same cycle as the request and the slave ready that cause it. Ownership and pointer changes take effect from the next cycle. The bench drives all inputs on the falling edge and samples the outputs 1 ns later, against a behavioural model of owners and pointers. It advances that model only at the rising edge, so every comparison reflects state committed at the previous edge. Directed phases fix the slave ready pattern, which makes the contention order and the stall cycles known in advance; a random phase then mixes regions, write enables and slave waits.

// File: rtl/mlx_pkg.sv
package mlx_pkg;
  localparam int NUM_SLV = 3;

  typedef enum logic [1:0] {
    SLV_FLASH  = 2'd0,
    SLV_SRAM   = 2'd1,
    SLV_BRIDGE = 2'd2,
    SLV_NONE   = 2'd3
  } slv_e;
endpackage

// File: rtl/mlx_decode.sv
module mlx_decode
  import mlx_pkg::*;
(
  input  logic [1:0] top_i,
  output slv_e       slv_o
);
  always_comb begin
    unique case (top_i)
      2'b00:   slv_o = SLV_FLASH;
      2'b01:   slv_o = SLV_SRAM;
      2'b10:   slv_o = SLV_BRIDGE;
      default: slv_o = SLV_NONE;
    endcase
  end
endmodule

// File: rtl/mlx_arb.sv
module mlx_arb #(
  parameter int NM = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NM-1:0] req_i,
  input  logic          ready_i,
  output logic [NM-1:0] gnt_o,
  output logic          valid_o
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic          busy_q;
  logic [NM-1:0] owner_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick;
  logic [IW-1:0] ptr_nxt;
  logic          found;
  logic [NM-1:0] pick_oh;

  // cyclic search starting at the pointer
  always_comb begin
    int c;
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NM; k++) begin
      c = int'(ptr_q) + k;
      if (c >= NM) c = c - NM;
      if (!found && req_i[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
  end

  assign pick_oh = found ? (NM'(1) << pick) : '0;
  assign ptr_nxt = (pick == IW'(NM - 1)) ? '0 : pick + 1'b1;
  assign gnt_o   = busy_q ? owner_q : pick_oh;
  assign valid_o = busy_q | found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else begin
      busy_q <= valid_o & ~ready_i;
      if (valid_o & ~ready_i) owner_q <= gnt_o;
      if (!busy_q && found) ptr_q <= ptr_nxt;
    end
  end

  AST_OWNER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> gnt_o == $past(gnt_o)); // R7
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R6
  AST_GNT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> |(gnt_o & req_i)); // R7
  AST_IDLE_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> req_i == '0); // R4
endmodule

// File: rtl/mlx_slv_mux.sv
module mlx_slv_mux #(
  parameter int NM = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic [NM-1:0]         gnt_i,
  input  logic [NM-1:0][AW-1:0] addr_i,
  input  logic [NM-1:0]         we_i,
  input  logic [NM-1:0][DW-1:0] wdata_i,
  output logic [AW-1:0]         addr_o,
  output logic                  we_o,
  output logic [DW-1:0]         wdata_o
);
  always_comb begin
    addr_o  = '0;
    we_o    = 1'b0;
    wdata_o = '0;
    for (int m = 0; m < NM; m++) begin
      addr_o  |= addr_i[m]  & {AW{gnt_i[m]}};
      we_o    |= we_i[m]    & gnt_i[m];
      wdata_o |= wdata_i[m] & {DW{gnt_i[m]}};
    end
  end
endmodule

// File: rtl/mlx_mst_resp.sv
module mlx_mst_resp
  import mlx_pkg::*;
#(
  parameter int NS = 3,
  parameter int DW = 32
) (
  input  logic                  req_i,
  input  slv_e                  tgt_i,
  input  logic [NS-1:0]         gnt_i,
  input  logic [NS-1:0]         ready_i,
  input  logic [NS-1:0][DW-1:0] rdata_i,
  output logic                  ready_o,
  output logic [DW-1:0]         rdata_o
);
  logic [NS-1:0] hit;

  assign hit = gnt_i & ready_i;

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NS; s++) rdata_o |= rdata_i[s] & {DW{hit[s]}};
    ready_o = (tgt_i == SLV_NONE) ? req_i : |hit;
  end
endmodule

// File: rtl/mlx_matrix.sv
module mlx_matrix
  import mlx_pkg::*;
#(
  parameter int NM = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NM-1:0]              m_req_i,
  input  logic [NM-1:0][AW-1:0]      m_addr_i,
  input  logic [NM-1:0]              m_we_i,
  input  logic [NM-1:0][DW-1:0]      m_wdata_i,
  output logic [NM-1:0]              m_ready_o,
  output logic [NM-1:0][DW-1:0]      m_rdata_o,
  output logic [NUM_SLV-1:0]         s_sel_o,
  output logic [NUM_SLV-1:0][AW-1:0] s_addr_o,
  output logic [NUM_SLV-1:0]         s_we_o,
  output logic [NUM_SLV-1:0][DW-1:0] s_wdata_o,
  input  logic [NUM_SLV-1:0]         s_ready_i,
  input  logic [NUM_SLV-1:0][DW-1:0] s_rdata_i
);
  localparam int NS = NUM_SLV;

  slv_e                  m_tgt [NM];
  logic [NS-1:0][NM-1:0] s_req;
  logic [NS-1:0][NM-1:0] s_gnt;
  logic [NM-1:0][NS-1:0] m_gnt;

  for (genvar m = 0; m < NM; m++) begin : g_dec
    mlx_decode u_dec (
      .top_i(m_addr_i[m][AW-1 -: 2]),
      .slv_o(m_tgt[m])
    );
  end

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < NM; m++) begin
        s_req[s][m] = m_req_i[m] && (m_tgt[m] == slv_e'(s));
        m_gnt[m][s] = s_gnt[s][m];
      end
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_slv
    mlx_arb #(.NM(NM)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (s_req[s]),
      .ready_i(s_ready_i[s]),
      .gnt_o  (s_gnt[s]),
      .valid_o(s_sel_o[s])
    );

    mlx_slv_mux #(.NM(NM), .AW(AW), .DW(DW)) u_mux (
      .gnt_i  (s_gnt[s]),
      .addr_i (m_addr_i),
      .we_i   (m_we_i),
      .wdata_i(m_wdata_i),
      .addr_o (s_addr_o[s]),
      .we_o   (s_we_o[s]),
      .wdata_o(s_wdata_o[s])
    );

    AST_STALL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_sel_o[s] && !s_ready_i[s] |=> $stable(s_addr_o[s]) && $stable(s_we_o[s])
        && $stable(s_wdata_o[s])); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !s_sel_o[s] |-> s_addr_o[s] == '0 && !s_we_o[s]); // R2
  end

  for (genvar m = 0; m < NM; m++) begin : g_mst
    mlx_mst_resp #(.NS(NS), .DW(DW)) u_resp (
      .req_i  (m_req_i[m]),
      .tgt_i  (m_tgt[m]),
      .gnt_i  (m_gnt[m]),
      .ready_i(s_ready_i),
      .rdata_i(s_rdata_i),
      .ready_o(m_ready_o[m]),
      .rdata_o(m_rdata_o[m])
    );

    AST_UNMAPPED_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_req_i[m] && m_addr_i[m][AW-1 -: 2] == 2'b11 |-> m_ready_o[m] && m_rdata_o[m] == '0); // R3
    AST_NO_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !m_req_i[m] |-> !m_ready_o[m]); // R8

    for (genvar s = 0; s < NS; s++) begin : g_chk
      AST_READY_OWNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_ready_o[m] && m_addr_i[m][AW-1 -: 2] == 2'(s) |-> s_sel_o[s] && s_ready_i[s]
          && s_addr_o[s] == m_addr_i[m]); // R8
    end
  end
endmodule

// File: tb/sim_mlx_matrix.sv
module sim_mlx_matrix;
  localparam int NM = 3;
  localparam int NS = 3;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct {
    logic [AW-1:0] a;
    logic          we;
    logic [DW-1:0] d;
  } txn_t;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NM-1:0]         m_req = '0;
  logic [NM-1:0][AW-1:0] m_addr = '0;
  logic [NM-1:0]         m_we = '0;
  logic [NM-1:0][DW-1:0] m_wdata = '0;
  logic [NM-1:0]         m_ready;
  logic [NM-1:0][DW-1:0] m_rdata;
  logic [NS-1:0]         s_sel;
  logic [NS-1:0][AW-1:0] s_addr;
  logic [NS-1:0]         s_we;
  logic [NS-1:0][DW-1:0] s_wdata;
  logic [NS-1:0]         s_ready = '0;
  logic [NS-1:0][DW-1:0] s_rdata = '0;

  mlx_matrix #(.NM(NM), .AW(AW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .m_req_i(m_req), .m_addr_i(m_addr), .m_we_i(m_we), .m_wdata_i(m_wdata),
    .m_ready_o(m_ready), .m_rdata_o(m_rdata),
    .s_sel_o(s_sel), .s_addr_o(s_addr), .s_we_o(s_we), .s_wdata_o(s_wdata),
    .s_ready_i(s_ready), .s_rdata_i(s_rdata)
  );

  always #2500ps clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  txn_t mq [NM][$];
  int   busy [NS];
  int   owner [NS];
  int   ptr [NS];
  int   cyc = 0;
  bit   rand_rdy = 1'b0;
  logic [NS-1:0] rdy_force = '1;
  int   done_log [$];
  logic [NM-1:0] samp_ready;
  logic [NS-1:0] samp_sel;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic int region(input logic [AW-1:0] a);
    return int'(a[AW-1 -: 2]);
  endfunction

  task automatic push(input int m, input logic [AW-1:0] a, input logic we, input logic [DW-1:0] d);
    txn_t t;
    t.a = a; t.we = we; t.d = d;
    mq[m].push_back(t);
  endtask

  task automatic step();
    int g [NS];
    int nreq [NS];
    bit exp_rdy [NM];
    @(negedge clk);
    cyc++;
    for (int m = 0; m < NM; m++) begin
      if (mq[m].size() > 0) begin
        m_req[m] = 1'b1; m_addr[m] = mq[m][0].a; m_we[m] = mq[m][0].we; m_wdata[m] = mq[m][0].d;
      end else begin
        m_req[m] = 1'b0;
      end
    end
    s_ready = rand_rdy ? NS'($urandom) : rdy_force;
    for (int s = 0; s < NS; s++) s_rdata[s] = {4'(s + 1), 28'(cyc)};
    #1ns;
    samp_ready = m_ready;
    samp_sel   = s_sel;
    for (int s = 0; s < NS; s++) begin
      nreq[s] = 0;
      for (int m = 0; m < NM; m++) if (m_req[m] && region(m_addr[m]) == s) nreq[s]++;
      g[s] = -1;
      if (busy[s] != 0) g[s] = owner[s];
      else for (int k = 0; k < NM; k++) begin
        int c;
        c = (ptr[s] + k) % NM;
        if (g[s] < 0 && m_req[c] && region(m_addr[c]) == s) g[s] = c;
      end
      chk(s_sel[s] == (g[s] >= 0), (busy[s] != 0) ? "R7" : ((nreq[s] > 1) ? "R6" : "R4"),
          $sformatf("sel s%0d", s), 64'(s_sel[s]), 64'(g[s] >= 0));
      if (g[s] >= 0) begin
        chk(s_addr[s] == m_addr[g[s]] && s_we[s] == m_we[g[s]] && s_wdata[s] == m_wdata[g[s]],
            (busy[s] != 0) ? "R7" : "R2", $sformatf("fwd s%0d", s), 64'(s_addr[s]), 64'(m_addr[g[s]]));
      end else begin
        chk(s_addr[s] == '0 && !s_we[s] && s_wdata[s] == '0, "R2",
            $sformatf("idle s%0d", s), 64'(s_addr[s]), 64'd0);
      end
    end
    for (int m = 0; m < NM; m++) begin
      int r;
      logic [DW-1:0] ed;
      r = region(m_addr[m]);
      ed = '0;
      if (!m_req[m]) exp_rdy[m] = 1'b0;
      else if (r == 3) exp_rdy[m] = 1'b1;
      else begin
        exp_rdy[m] = (g[r] == m) && s_ready[r];
        if (exp_rdy[m]) ed = s_rdata[r];
      end
      chk(m_ready[m] == exp_rdy[m] && m_rdata[m] == ed, (m_req[m] && r == 3) ? "R3" : "R8",
          $sformatf("resp m%0d", m), {31'd0, m_ready[m], m_rdata[m]}, {31'd0, exp_rdy[m], ed});
    end
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      if (g[s] >= 0) begin
        if (busy[s] == 0) ptr[s] = (g[s] + 1) % NM;
        busy[s]  = s_ready[s] ? 0 : 1;
        owner[s] = g[s];
      end else busy[s] = 0;
    end
    for (int m = 0; m < NM; m++) if (exp_rdy[m]) begin
      void'(mq[m].pop_front());
      done_log.push_back(m);
    end
  endtask

  initial begin
    #(200000 * 5ns);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin busy[s] = 0; owner[s] = 0; ptr[s] = 0; end
    #12ns;
    chk(s_sel == '0 && m_ready == '0, "R1", "in reset", {m_ready, s_sel}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(samp_sel == '0 && samp_ready == '0, "R1", "after reset idle", {samp_ready, samp_sel}, 64'd0);

    // lone request to idle SRAM port
    rdy_force = '1;
    push(1, 32'h4000_0010, 1'b1, 32'hCAFE_0001);
    step();
    chk(samp_sel == 3'b010 && samp_ready == 3'b010, "R4", "same-cycle grant",
        {samp_ready, samp_sel}, {3'b010, 3'b010});

    // three masters, three ports
    push(0, 32'h0000_0100, 1'b0, 32'h0);
    push(1, 32'h4000_0200, 1'b1, 32'h1111_2222);
    push(2, 32'h8000_0300, 1'b0, 32'h0);
    step();
    chk(samp_ready == 3'b111 && samp_sel == 3'b111, "R5", "parallel service",
        {samp_ready, samp_sel}, {3'b111, 3'b111});

    // contention on flash with slave stall; flash pointer is 1 here
    done_log.delete();
    push(0, 32'h0000_0A00, 1'b0, 32'h0);
    push(1, 32'h0000_0B00, 1'b1, 32'hBBBB_0000);
    push(2, 32'h0000_0C00, 1'b1, 32'hCCCC_0000);
    rdy_force = 3'b110;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(s_addr[0] == 32'h0000_0B00 && samp_ready == '0, "R7", "owner held in stall",
          64'(s_addr[0]), 64'h0B00);
    end
    rdy_force = '1;
    for (int i = 0; i < 3; i++) step();
    chk(done_log.size() == 3 && done_log[0] == 1 && done_log[1] == 2 && done_log[2] == 0,
        "R6", "round-robin order",
        (done_log.size() == 3) ? 64'(done_log[0] * 100 + done_log[1] * 10 + done_log[2]) : 64'hFFFF,
        64'd120);

    // unmapped region
    push(2, 32'hC000_0044, 1'b0, 32'h0);
    step();
    chk(samp_ready == 3'b100 && samp_sel == '0, "R3", "unmapped ack",
        {samp_ready, samp_sel}, {3'b100, 3'b000});

    // random traffic
    rand_rdy = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      for (int m = 0; m < NM; m++) if (mq[m].size() == 0 && ($urandom % 2) == 1)
        push(m, {2'($urandom), 30'($urandom)}, 1'($urandom), $urandom);
      step();
    end
    rand_rdy = 1'b0;
    rdy_force = '1;
    for (int i = 0; i < 8; i++) step();

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule